// File: doc/BRIEF.md
# Bus Acknowledge Generator with Per-Device Wait

This block produces the active-low transfer acknowledge for an asynchronous, strobe-based processor bus. It watches the active-low address strobe and a set of device select lines that a decoder drives, one line per device. When the strobe is asserted and a device is selected, the block asserts acknowledge after a wait that depends on that device. One designated slow peripheral gets a longer wait than the others. Both bus inputs are asynchronous to the block clock, so they pass through a flop synchronizer before any decision is made. The acknowledge output comes straight from a flop.

A mode input chooses how acknowledge is released. In corrected mode, acknowledge negates on the first clock that samples the synchronized strobe as negated. In legacy mode, the release is stretched by the same wait that applied when acknowledge was asserted. As a result, acknowledge can still be active after the next bus cycle's strobe has begun. That next cycle is held off until the stretched release completes. A strobe that stays asserted across a read-modify-write access keeps acknowledge asserted without any break.

Top module: `bus_ack_gen`

## Requirements
- R1: While reset is high, and on the first clock after reset is raised, `bus_ack_n` is 1 (negated) and the block is idle.
- R2: With the default two synchronizer stages, if the strobe and a fast-device select change just after a rising edge, `bus_ack_n` falls on the 3rd following rising edge plus FAST_WAIT. With the default FAST_WAIT of 0, this is the 3rd edge.
- R3: When the select bit at index SLOW_IDX (default 1) is among the asserted selects, `bus_ack_n` falls SLOW_WAIT edges later than for a fast device. With the default SLOW_WAIT of 2, this is the 5th edge.
- R4: A strobe with every select bit at 0 never produces an acknowledge.
- R5: If the strobe negates before the wait ends, no acknowledge is produced, and the block returns to idle.
- R6: In corrected mode (`legacy_mode` = 0), `bus_ack_n` rises on the 3rd rising edge after the strobe is negated.
- R7: In legacy mode (`legacy_mode` = 1), the release is delayed by the wait of the access that is ending: the 5th edge for the slow device and the 3rd edge for a fast device.
- R8: While the strobe stays asserted after acknowledge, acknowledge remains asserted for every cycle, as in a read-modify-write access.
- R9: In legacy mode, if a new strobe arrives while a stretched release is pending, acknowledge first negates on schedule. The new access's wait begins on the next clock after that.
- R10: In corrected mode, a new strobe that follows a one-cycle strobe gap starts its wait on the clock right after the release.
- R11: The wait length is captured when the access starts. Select changes later in the same access alter neither the assertion nor the legacy release timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_as_n | input | 1 | Asynchronous address strobe, active low |
| dev_sel | input | N_DEV | Asynchronous decoded device selects, one bit per device, active high |
| legacy_mode | input | 1 | 1 = release delayed by the access wait, 0 = release tied to strobe |
| bus_ack_n | output | 1 | Registered transfer acknowledge, active low |

## Verification
In legacy mode, the stretched release of one access and the start of the next access's wait can fall in the same cycle. They collide when the strobe is negated for a single cycle and then asserted again at once, toward the slow device. The bench samples acknowledge after every edge of that sequence. The expected pattern is acknowledge still low while the new strobe is already in, a high gap of exactly the drain length, and then a fresh full wait. The same gap in corrected mode is checked against its own, shorter pattern.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HELD  = 2'd2,
        ST_DRAIN = 2'd3
    } ack_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned count_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/bus_ack_sync.sv
module bus_ack_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bus_ack_wait_sel.sv
module bus_ack_wait_sel #(
    parameter int unsigned N_DEV     = 4,
    parameter int unsigned SLOW_IDX  = 1,
    parameter int unsigned FAST_WAIT = 0,
    parameter int unsigned SLOW_WAIT = 2,
    parameter int unsigned CNT_W     = 2
) (
    input  logic [N_DEV-1:0] sel,
    output logic             hit,
    output logic [CNT_W-1:0] wait_len
);
    logic [CNT_W-1:0] gated [N_DEV];

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        localparam int unsigned DEV_WAIT = (i == SLOW_IDX) ? SLOW_WAIT : FAST_WAIT;
        assign gated[i] = sel[i] ? CNT_W'(DEV_WAIT) : '0;
    end

    always_comb begin
        wait_len = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (gated[i] > wait_len) wait_len = gated[i];
        end
    end

    assign hit = |sel;
endmodule

// File: rtl/bus_ack_fsm.sv
module bus_ack_fsm
    import bus_ack_pkg::*;
#(
    parameter int unsigned CNT_W    = 2,
    parameter int unsigned MAX_WAIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_s_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] wait_len,
    input  logic             legacy_mode,
    output logic             ack_n
);
    ack_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] held_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            held_wait <= '0;
            ack_n     <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!as_s_n && hit) begin
                        held_wait <= wait_len;
                        if (wait_len == '0) begin
                            ack_n <= 1'b0;
                            state <= ST_HELD;
                        end else begin
                            cnt   <= wait_len;
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (as_s_n) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else if (cnt == CNT_W'(1)) begin
                        cnt   <= '0;
                        ack_n <= 1'b0;
                        state <= ST_HELD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HELD: begin
                    if (as_s_n) begin
                        if (legacy_mode && held_wait != '0) begin
                            cnt   <= held_wait;
                            state <= ST_DRAIN;
                        end else begin
                            ack_n <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (cnt == CNT_W'(1)) begin
                        cnt   <= '0;
                        ack_n <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: reset forces acknowledge negated and the machine idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ack_n && state == ST_IDLE));

    // R5: acknowledge only ever asserts while the synchronized strobe is in
    assert_ack_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> !$past(as_s_n));

    // R3: the wait counter never exceeds the longest configured wait
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_WAIT));

    // R6: corrected mode drops acknowledge on the first negated-strobe sample
    assert_corrected_release_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD && as_s_n && !legacy_mode) |=> ack_n);

    // R8: a strobe held after acknowledge keeps acknowledge asserted
    assert_hold_while_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HELD && !as_s_n) |=> !ack_n);

    // R9: while a stretched release drains, acknowledge is still asserted
    assert_drain_keeps_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> !ack_n);
endmodule

// File: rtl/bus_ack_gen.sv
module bus_ack_gen
    import bus_ack_pkg::*;
#(
    parameter int unsigned N_DEV       = 4,
    parameter int unsigned SLOW_IDX    = 1,
    parameter int unsigned FAST_WAIT   = 0,
    parameter int unsigned SLOW_WAIT   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_as_n,
    input  logic [N_DEV-1:0] dev_sel,
    input  logic             legacy_mode,
    output logic             bus_ack_n
);
    localparam int unsigned MAX_WAIT = max_u(FAST_WAIT, SLOW_WAIT);
    localparam int unsigned CNT_W    = count_width(MAX_WAIT);
    localparam int unsigned SYNC_W   = N_DEV + 1;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {N_DEV{1'b0}}};

    logic [SYNC_W-1:0] sync_q;
    logic              as_s_n;
    logic [N_DEV-1:0]  sel_s;
    logic              hit;
    logic [CNT_W-1:0]  wait_len;

    bus_ack_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_as_n, dev_sel}),
        .q   (sync_q)
    );

    assign as_s_n = sync_q[SYNC_W-1];
    assign sel_s  = sync_q[N_DEV-1:0];

    bus_ack_wait_sel #(
        .N_DEV     (N_DEV),
        .SLOW_IDX  (SLOW_IDX),
        .FAST_WAIT (FAST_WAIT),
        .SLOW_WAIT (SLOW_WAIT),
        .CNT_W     (CNT_W)
    ) u_wait_sel (
        .sel      (sel_s),
        .hit      (hit),
        .wait_len (wait_len)
    );

    bus_ack_fsm #(
        .CNT_W    (CNT_W),
        .MAX_WAIT (MAX_WAIT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .as_s_n      (as_s_n),
        .hit         (hit),
        .wait_len    (wait_len),
        .legacy_mode (legacy_mode),
        .ack_n       (bus_ack_n)
    );
endmodule

// File: tb/bus_ack_gen_tb.sv
`timescale 1ns/1ps
module bus_ack_gen_tb;
    localparam int N_DEV  = 4;
    localparam int LAT_F  = 3;      // R2: 2 sync stages + 1 + FAST_WAIT(0)
    localparam int LAT_S  = 5;      // R3: 2 sync stages + 1 + SLOW_WAIT(2)
    localparam int LIMIT  = 20;

    typedef struct packed {
        logic [3:0] sel;
        logic       leg;
        logic [7:0] hold;
        logic [3:0] a_lat;
        logic [3:0] r_lat;
    } vec_t;

    // sel bit 1 is the slow device
    localparam vec_t VECS [8] = '{
        '{4'b0001, 1'b0, 8'd2, 4'(LAT_F), 4'(LAT_F)},
        '{4'b0010, 1'b0, 8'd2, 4'(LAT_S), 4'(LAT_F)},
        '{4'b0010, 1'b1, 8'd3, 4'(LAT_S), 4'(LAT_S)},
        '{4'b0100, 1'b1, 8'd1, 4'(LAT_F), 4'(LAT_F)},
        '{4'b1000, 1'b0, 8'd9, 4'(LAT_F), 4'(LAT_F)},
        '{4'b0011, 1'b1, 8'd2, 4'(LAT_S), 4'(LAT_S)},
        '{4'b0110, 1'b0, 8'd4, 4'(LAT_S), 4'(LAT_F)},
        '{4'b1100, 1'b1, 8'd12, 4'(LAT_F), 4'(LAT_F)}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_as_n = 1'b1;
    logic [N_DEV-1:0] dev_sel = '0;
    logic             legacy_mode = 1'b0;
    logic             bus_ack_n;

    int applied = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    bus_ack_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_as_n    (bus_as_n),
        .dev_sel     (dev_sel),
        .legacy_mode (legacy_mode),
        .bus_ack_n   (bus_ack_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        applied++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input logic target, output int lat);
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end while (bus_ack_n != target && lat < LIMIT);
    endtask

    task automatic idle(input int n);
        bus_as_n = 1'b1;
        dev_sel  = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic gap_test(input logic leg, input logic [7:0] exp_seq, input string req);
        int lat;
        legacy_mode = leg;
        dev_sel  = 4'b0010;
        bus_as_n = 1'b0;
        measure(1'b0, lat);
        chk(req, lat, LAT_S);
        bus_as_n = 1'b1;
        @(negedge clk);
        chk(req, int'(bus_ack_n), int'(exp_seq[7]));
        bus_as_n = 1'b0;
        for (int k = 6; k >= 0; k--) begin
            @(negedge clk);
            chk(req, int'(bus_ack_n), int'(exp_seq[k]));
        end
        bus_as_n = 1'b1;
        measure(1'b1, lat);
        idle(6);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk("R1 ack negated in reset", int'(bus_ack_n), 1);
        rst = 1'b0;
        idle(3);
        chk("R1 ack negated after reset", int'(bus_ack_n), 1);

        // table walk: R2 R3 R6 R7 R8
        foreach (VECS[i]) begin
            legacy_mode = VECS[i].leg;
            dev_sel     = VECS[i].sel;
            bus_as_n    = 1'b0;
            measure(1'b0, lat);
            chk("R2/R3 assert latency", lat, int'(VECS[i].a_lat));
            for (int h = 0; h < int'(VECS[i].hold); h++) begin
                @(negedge clk);
                chk("R8 ack held during strobe", int'(bus_ack_n), 0);
            end
            bus_as_n = 1'b1;
            measure(1'b1, lat);
            chk("R6/R7 release latency", lat, int'(VECS[i].r_lat));
            idle(4);
        end

        // R4: strobe with no select
        legacy_mode = 1'b0;
        dev_sel  = '0;
        bus_as_n = 1'b0;
        measure(1'b0, lat);
        chk("R4 no select never acks", int'(bus_ack_n), 1);
        idle(4);

        // R5: strobe withdrawn during the slow wait
        dev_sel  = 4'b0010;
        bus_as_n = 1'b0;
        @(negedge clk);
        bus_as_n = 1'b1;
        measure(1'b0, lat);
        chk("R5 aborted access not acked", int'(bus_ack_n), 1);
        idle(4);
        dev_sel  = 4'b0001;
        bus_as_n = 1'b0;
        measure(1'b0, lat);
        chk("R5 idle again after abort", lat, LAT_F);
        idle(6);

        // R9: legacy gap, edges e1..e8
        gap_test(1'b1, 8'b0000_1110, "R9 legacy pending release");
        // R10: corrected gap, edges e1..e8
        gap_test(1'b0, 8'b0011_1000, "R10 corrected back-to-back");

        // R11: select changes inside one access
        legacy_mode = 1'b1;
        dev_sel  = 4'b0010;
        bus_as_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        dev_sel = 4'b0001;
        measure(1'b0, lat);
        chk("R11 assert wait latched", lat + 2, LAT_S);
        dev_sel = 4'b0001;
        repeat (2) @(negedge clk);
        bus_as_n = 1'b1;
        measure(1'b1, lat);
        chk("R11 legacy release uses latched wait", lat, LAT_S);
        idle(4);

        // R1: reset in the middle of an acknowledged access
        dev_sel  = 4'b0001;
        bus_as_n = 1'b0;
        measure(1'b0, lat);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-access reset negates ack", int'(bus_ack_n), 1);
        rst = 1'b0;
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule